// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block answers commands arriving on a three-wire serial link (chip select, serial clock and serial data in) and replies on a serial data output that has its own output enable. It holds 256 words of 16 bits in an internal register array. A command is a 1 start bit, a two-bit opcode and an eight-bit address, all sent MSB first. The block supports single and continuous sequential reads, a write command used to preload contents, and commands that set or clear a write-enable latch.

All three link inputs pass through two-flop synchronisers into the system clock domain. A rising edge of the serial clock is found by comparing the synchronised clock with its previous value, and input bits are taken on those edges. The serial link has no parallel data stream, so there is no valid/ready handshake and no back-pressure: the master sets the pace through the serial clock. For each read, the output first drives one zero bit and then word after word. Between words the address goes up by one and wraps at the top. There is no separator bit between words.

Top module: `tw_eeprom`

## Requirements
- R1: After reset the output enable is low, the write-enable latch is clear and every stored word reads as 0x0000.
- R2: Serial clock rising edges that see a 0 before the start bit are ignored. After the 1 start bit the block takes two opcode bits and then eight address bits, MSB first.
- R3: READ is opcode 10. On the rising edge that delivers address bit A0, the output enable goes high and the output drives a single 0 bit.
- R4: After the dummy bit, each following rising edge of the serial clock puts out the next bit of the word, MSB first. The output changes only after a rising edge.
- R5: While chip select stays high, the word after bit 0 is the word at the next address. It follows on the next rising edge with no dummy bit in between.
- R6: Sequential reading past address 0xFF continues at address 0x00.
- R7: WRITE is opcode 01, followed by the address and 16 data bits MSB first. The word is stored after the 16th bit, but only when the write-enable latch is set. Otherwise the stored word is left unchanged.
- R8: Opcode 00 with address bits [7:6] = 11 sets the write-enable latch, and opcode 00 with [7:6] = 00 clears it. The latch does not affect reads.
- R9: Driving chip select low ends any command. The output enable falls, and a WRITE that has received fewer than 16 data bits leaves the storage unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high, asynchronous |
| sck_i | input | 1 | Serial clock from the master, asynchronous |
| sdi_i | input | 1 | Serial data in, sampled on rising serial clock edges |
| sdo_o | output | 1 | Serial data out, held 0 while not enabled |
| sdo_oe_o | output | 1 | Output enable for the serial data pad (low means high impedance) |

## Verification
Several input patterns are used. A single-word read of a written address confirms the dummy bit and MSB-first order. A three-word read that starts at 0xFF separates correct wraparound from running past the top, and a missing or repeated dummy bit between words shows up as a shifted bit stream. Writes sent before EWEN, after EWEN and after EWDS distinguish a latch that gates writes from one that is ignored or stuck. A read preceded by leading zeros checks that the start bit is found, and a write cut short by chip select shows whether partial data leaks into storage.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_WDATA, ST_READ, ST_HOLD
  } tw_state_e;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  localparam logic [1:0] EXT_WEN = 2'b11;
  localparam logic [1:0] EXT_WDS = 2'b00;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      q    <= '0;
    end else begin
      s1_q <= d;
      q    <= s1_q;
    end
  end
endmodule

// File: rtl/tw_mem.sv
module tw_mem #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] arr_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) arr_q[i] <= '0;
    end else if (we) begin
      arr_q[waddr] <= wdata;
    end
  end

  assign rdata = arr_q[raddr];
endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl
  import tw_eeprom_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          sck_rise,
  input  logic          sdi,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic [AW-1:0] rd_addr,
  output logic          sdo,
  output logic          oe,
  output logic          wen_q
);
  localparam int OPC_W   = 2;
  localparam int CNT_MAX = (DW > AW) ? DW : AW;
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int BW      = $clog2(DW);

  tw_state_e     st_q;
  logic [1:0]    opc_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bit_q;
  logic [AW-1:0] addr_nx;
  logic [DW-1:0] data_nx;

  assign addr_nx   = {addr_q[AW-2:0], sdi};
  assign data_nx   = {data_q[DW-2:0], sdi};
  assign mem_waddr = addr_q;
  assign mem_wdata = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      opc_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      cnt_q   <= '0;
      bit_q   <= '0;
      rd_addr <= '0;
      sdo     <= 1'b0;
      oe      <= 1'b0;
      wen_q   <= 1'b0;
      mem_we  <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      if (!cs) begin
        st_q  <= ST_IDLE;
        oe    <= 1'b0;
        sdo   <= 1'b0;
        cnt_q <= '0;
      end else if (sck_rise) begin
        unique case (st_q)
          ST_IDLE: begin
            if (sdi) begin
              st_q  <= ST_OPC;
              cnt_q <= '0;
            end
          end
          ST_OPC: begin
            opc_q <= {opc_q[0], sdi};
            if (cnt_q == CW'(OPC_W - 1)) begin
              st_q  <= ST_ADDR;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_ADDR: begin
            addr_q <= addr_nx;
            if (cnt_q == CW'(AW - 1)) begin
              cnt_q <= '0;
              case (opc_q)
                OP_READ: begin
                  st_q    <= ST_READ;
                  rd_addr <= addr_nx;
                  bit_q   <= BW'(DW - 1);
                  oe      <= 1'b1;
                  sdo     <= 1'b0;
                end
                OP_WRITE: st_q <= ST_WDATA;
                OP_EXT: begin
                  if (addr_nx[AW-1 -: 2] == EXT_WEN)      wen_q <= 1'b1;
                  else if (addr_nx[AW-1 -: 2] == EXT_WDS) wen_q <= 1'b0;
                  st_q <= ST_HOLD;
                end
                default: st_q <= ST_HOLD;
              endcase
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_WDATA: begin
            data_q <= data_nx;
            if (cnt_q == CW'(DW - 1)) begin
              mem_we <= wen_q;
              st_q   <= ST_HOLD;
              cnt_q  <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_READ: begin
            sdo <= mem_rdata[bit_q];
            if (bit_q == '0) begin
              bit_q   <= BW'(DW - 1);
              rd_addr <= rd_addr + 1'b1;
            end else begin
              bit_q <= bit_q - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tw_eeprom.sv
module tw_eeprom #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic sck_i,
  input  logic sdi_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  logic [2:0]        sync_q;
  logic              cs_s, sck_s, sdi_s;
  logic              sck_d;
  logic              sck_rise;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] mem_rdata;
  logic              sdo;
  logic              oe;
  logic              wen_q;

  tw_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_i, sck_i, sdi_i}), .q(sync_q)
  );
  assign {cs_s, sck_s, sdi_s} = sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_s;
  end
  assign sck_rise = sck_s & ~sck_d & cs_s;

  tw_mem #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(mem_waddr),
    .wdata(mem_wdata), .raddr(rd_addr), .rdata(mem_rdata)
  );

  tw_ctrl #(.AW(ADDR_W), .DW(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cs(cs_s), .sck_rise(sck_rise), .sdi(sdi_s),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .rd_addr(rd_addr), .sdo(sdo), .oe(oe),
    .wen_q(wen_q)
  );

  assign sdo_o    = sdo & oe;
  assign sdo_oe_o = oe;
endmodule

// File: rtl/tw_eeprom_chk.sv
module tw_eeprom_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_i,
  input logic              sdo_o,
  input logic              sdo_oe_o,
  input logic              sck_rise,
  input logic              wen_q,
  input logic              mem_we,
  input logic [ADDR_W-1:0] rd_addr
);
  // R9
  cs_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_i && !$past(cs_i) && !$past(cs_i, 2) && !$past(cs_i, 3)) |-> !sdo_oe_o);

  // R3
  dummy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe_o) |-> !sdo_o);

  // R4
  sdo_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe_o && $past(sdo_oe_o) && (sdo_o != $past(sdo_o))) |-> $past(sck_rise));

  // R7
  write_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wen_q);

  // R6
  addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe_o && $past(sdo_oe_o) && $past(rd_addr) == '1 && rd_addr != $past(rd_addr))
      |-> rd_addr == '0);
endmodule

bind tw_eeprom tw_eeprom_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
  .sck_rise(sck_rise), .wen_q(wen_q), .mem_we(mem_we), .rd_addr(rd_addr)
);

// File: tb/tw_eeprom_tb.sv
module tw_eeprom_tb;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0;
  logic sck = 1'b0;
  logic sdi = 1'b0;
  logic sdo, sdo_oe;
  logic mon_en = 1'b0;

  int errors = 0;
  int checks = 0;

  logic [15:0] model [256];
  logic        wen_m = 1'b0;
  bit          exp_q [$];
  string       tag_q [$];

  always #2.5 clk = ~clk;

  tw_eeprom u_dut (
    .clk(clk), .rst_n(rst_n), .cs_i(cs), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pop one expected bit at each serial clock fall
  always @(negedge sck) begin
    if (mon_en) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 extra bit", 0, 1);
      end else begin
        bit    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(sdo_oe === 1'b1 && sdo === e, t, {sdo_oe, sdo}, {1'b1, e});
      end
    end
  end

  task automatic send_bit(input logic b);
    @(negedge clk);
    sdi = b;
    sck = 1'b0;
    repeat (H) @(negedge clk);
    sck = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_on();
    @(negedge clk);
    sck = 1'b0;
    cs = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic cs_off();
    @(negedge clk);
    sck = 1'b0;
    repeat (H) @(negedge clk);
    cs = 1'b0;
    repeat (2 * H) @(negedge clk);
  endtask

  task automatic send_head(input logic [1:0] opc, input logic [7:0] addr);
    send_bit(1'b1);
    for (int i = 1; i >= 0; i--) send_bit(opc[i]);
    for (int i = 7; i >= 0; i--) send_bit(addr[i]);
  endtask

  task automatic do_ext(input logic [1:0] top);
    cs_on();
    send_head(2'b00, {top, 6'b010101});
    cs_off();
    if (top == 2'b11) wen_m = 1'b1;
    if (top == 2'b00) wen_m = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] addr, input logic [15:0] d);
    cs_on();
    send_head(2'b01, addr);
    for (int i = 15; i >= 0; i--) send_bit(d[i]);
    cs_off();
    if (wen_m) model[addr] = d;
  endtask

  // Driver: pushes expected stream, then clocks it out
  task automatic do_read(input logic [7:0] addr, input int nw, input int lead, input string tg);
    cs_on();
    for (int i = 0; i < lead; i++) send_bit(1'b0);
    send_head(2'b10, addr);
    exp_q.push_back(1'b0);
    tag_q.push_back("R3 dummy");
    for (int w = 0; w < nw; w++) begin
      logic [7:0] a;
      a = addr + 8'(w);
      for (int b = 15; b >= 0; b--) begin
        exp_q.push_back(model[a][b]);
        tag_q.push_back(tg);
      end
    end
    mon_en = 1'b1;
    for (int i = 0; i < nw * 16; i++) send_bit(1'b0);
    @(negedge clk);
    sck = 1'b0;
    repeat (H) @(negedge clk);
    mon_en = 1'b0;
    chk(exp_q.size() == 0, "R5 missing bits", exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
    cs_off();
    // R9: enable gone after chip select drops
    chk(sdo_oe === 1'b0, "R9 oe after cs low", sdo_oe, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 16'h0000;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(sdo_oe === 1'b0 && sdo === 1'b0, "R1 reset outputs", {sdo_oe, sdo}, 0);
    do_read(8'h10, 1, 0, "R1 cleared word");

    // R7: write with latch clear is ignored
    do_write(8'h03, 16'hABCD);
    do_read(8'h03, 1, 0, "R7 write blocked");

    // R8: EWEN opens writes
    do_ext(2'b11);
    do_write(8'h03, 16'hABCD);
    do_write(8'h04, 16'h1357);
    do_read(8'h03, 1, 0, "R4 R7 single word");

    // R2: leading zeros before the start bit
    do_read(8'h04, 1, 3, "R2 leading zeros");

    // R5: sequential across two words
    do_read(8'h03, 2, 0, "R5 sequential");

    // R6: wrap at top
    do_write(8'hFF, 16'h8001);
    do_write(8'h00, 16'h7FFE);
    do_write(8'h01, 16'hC35A);
    do_read(8'hFF, 3, 0, "R6 wrap");

    // R9: write aborted after 8 data bits
    cs_on();
    send_head(2'b01, 8'h04);
    for (int i = 0; i < 8; i++) send_bit(1'b1);
    cs_off();
    do_read(8'h04, 1, 0, "R9 aborted write");

    // R8: EWDS blocks writes, reads still work
    do_ext(2'b00);
    do_write(8'h03, 16'h0F0F);
    do_read(8'h03, 1, 0, "R8 after EWDS");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule